// File: doc/BRIEF.md
# Synchronous Offset Bus Write Engine

This block is the sending side of a parallel storage bus while the target returns data to the initiator. Upstream logic hands it 32-bit words over a ready/valid port. Each word carries two 9-bit bus symbols, and parity is already included. The engine puts each symbol on the data bus and strobes it with REQ. It counts the ACK pulses that return, and it raises a done flag once the transfer has fully drained.

The offset setting selects one of two pacing schemes. A non-zero offset selects synchronous mode. In this mode REQ pulses run ahead of ACKs, but only up to a window of unacknowledged strobes. The setup, assertion and hold times of each strobe come from the negotiated period code, using a fast or a slow timing profile. An offset of zero selects the fully interlocked handshake: each REQ waits for its ACK and for that ACK's release before the next symbol goes out.

The offset and period inputs are latched every cycle while the engine is idle. They must be held stable for at least one cycle before the first word is offered.

Top module: `scsi_sync_tx`

## Requirements
- R1: Each accepted word yields two symbols. Bits [8:0] go out first and bits [24:16] second. Bits [15:9] and [31:25] are ignored.
- R2: The symbol on `data_o` is stable for the whole time `req_o` is high. It is the value the receiver samples on the REQ rising edge.
- R3: In synchronous mode, let the period code be at most 25. Then the setup delay is 3 and the assertion delay is 5. Any larger code gives 6 and 12. Each phase lasts its delay plus one clock. REQ is therefore high for assertion+1 cycles. Unthrottled rising edges of REQ are setup+assertion+hold+3 cycles apart.
- R4: The hold delay equals floor(period_code*4/8) − setup − assertion − 3, clamped to the range 0..15.
- R5: In synchronous mode, the count of REQ pulses not yet matched by an ACK never exceeds the offset. At the limit the engine stalls with data driven, and it resumes after an ACK.
- R6: An offset above 16 is treated as 16.
- R7: An offset of zero selects the interlocked mode. At most one REQ is ever outstanding. REQ falls only after ACK is seen high. The next symbol waits until ACK is seen low again.
- R8: ACK passes through a two-flop synchroniser. Each ACK assertion counts once, however long it is held.
- R9: `done_o` is high only under all of these conditions: the engine is idle, no word is offered, every REQ has been acknowledged, and the synchronised ACK is low.
- R10: Changes to the offset or period inputs while a transfer is running have no effect on that transfer.
- R11: After reset and whenever idle, `req_o` and `data_oe_o` are low. `data_oe_o` is high while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Two packed symbols |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Word accepted on this edge if valid |
| offset_i | input | 5 | Unacknowledged REQ window, 0 = interlocked |
| period_i | input | 8 | Negotiated period in 4 ns units |
| ack_i | input | 1 | ACK from the initiator (asynchronous) |
| req_o | output | 1 | REQ strobe, high = asserted |
| data_o | output | 9 | Bus symbol: data and parity |
| data_oe_o | output | 1 | Data bus drive enable |
| done_o | output | 1 | Transfer fully sent and acknowledged |

## Verification
Some properties are checked by assertions on every cycle. The window bound is checked at every REQ rise, and the interlocked mode is held to a single outstanding strobe. The symbol must stay stable under REQ. REQ must be quiet whenever the bus is not driven or done is high.

Other behaviours only show up in the bench scenarios. These cover the symbol order across word boundaries and the exact strobe widths and spacings for each timing profile and clamp case. They also show that a slow ACK stream actually fills the window, that the offset clamp applies, that mid-transfer configuration changes are ignored, and that done is held back while ACKs are missing.

// File: rtl/scsi_tx_pkg.sv
package scsi_tx_pkg;
  localparam int SYM_W    = 9;
  localparam int WORD_W   = 32;
  localparam int HI_LSB   = 16;
  localparam int DLY_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ASSERT,
    ST_HOLD,
    ST_RELEASE
  } tx_state_e;
endpackage

// File: rtl/scsi_tx_timing.sv
module scsi_tx_timing #(
  parameter int PER_W    = 8,
  parameter int DLY_W    = 4,
  parameter int FAST_MAX = 25,
  parameter int FAST_D0  = 3,
  parameter int FAST_D1  = 5,
  parameter int SLOW_D0  = 6,
  parameter int SLOW_D1  = 12
) (
  input  logic [PER_W-1:0] period_i,
  output logic [DLY_W-1:0] d0_o,
  output logic [DLY_W-1:0] d1_o,
  output logic [DLY_W-1:0] d2_o
);
  localparam int DLY_MAX = (1 << DLY_W) - 1;

  int total, rem, s0, s1;

  always_comb begin
    if (int'(period_i) <= FAST_MAX) begin
      s0 = FAST_D0;
      s1 = FAST_D1;
    end else begin
      s0 = SLOW_D0;
      s1 = SLOW_D1;
    end
    total = (int'(period_i) * 4) / 8;
    rem   = total - s0 - s1 - 3;
    if (rem < 0)       rem = 0;
    if (rem > DLY_MAX) rem = DLY_MAX;
    d0_o = DLY_W'(s0);
    d1_o = DLY_W'(s1);
    d2_o = DLY_W'(rem);
  end
endmodule

// File: rtl/scsi_tx_ack_sync.sv
module scsi_tx_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= ack_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/scsi_tx_credit.sv
module scsi_tx_credit #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             open_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dec_ok;

  assign dec_ok = dec_i && (cnt_q != '0 || inc_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_ok) cnt_q <= cnt_q + 1'b1;
    else if (!inc_i && dec_ok) cnt_q <= cnt_q - 1'b1;

  assign count_o = cnt_q;
  assign open_o  = cnt_q < limit_i;
  assign empty_o = cnt_q == '0;

  AST_INC_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> cnt_q < limit_i); // R5
endmodule

// File: rtl/scsi_sync_tx.sv
module scsi_sync_tx
  import scsi_tx_pkg::*;
#(
  parameter int OFF_W       = 5,
  parameter int PER_W       = 8,
  parameter int OFF_MAX     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [SYM_W-1:0]  data_o,
  output logic              data_oe_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(OFF_MAX + 1);

  tx_state_e        state_q;
  logic [SYM_W-1:0] data_q, sym1_q;
  logic             sel_q, async_q;
  logic [DLY_W-1:0] cnt_q;
  logic [CNT_W-1:0] offset_q, limit;
  logic [PER_W-1:0] period_q;
  logic [DLY_W-1:0] d0, d1, d2;
  logic             ack_lvl, ack_rise;
  logic [CNT_W-1:0] out_cnt;
  logic             credit_open, out_empty;
  logic             idle, sym_end, need_word, take, fire_req;
  logic [CNT_W-1:0] off_clamp;

  scsi_tx_timing #(.PER_W(PER_W), .DLY_W(DLY_W)) u_timing (
    .period_i (period_q),
    .d0_o     (d0),
    .d1_o     (d1),
    .d2_o     (d2)
  );

  scsi_tx_ack_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_i   (ack_i),
    .level_o (ack_lvl),
    .rise_o  (ack_rise)
  );

  // interlocked mode is a window of one
  assign limit = async_q ? CNT_W'(1) : offset_q;

  scsi_tx_credit #(.CNT_W(CNT_W)) u_credit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (fire_req),
    .dec_i   (ack_rise),
    .limit_i (limit),
    .count_o (out_cnt),
    .open_o  (credit_open),
    .empty_o (out_empty)
  );

  always_comb begin
    if (int'(offset_i) > OFF_MAX) off_clamp = CNT_W'(OFF_MAX);
    else                          off_clamp = CNT_W'(offset_i);
  end

  assign idle      = state_q == ST_IDLE;
  assign sym_end   = (state_q == ST_HOLD && cnt_q == '0) ||
                     (state_q == ST_RELEASE && !ack_lvl);
  assign need_word = idle || (sym_end && sel_q);
  assign take      = need_word && word_valid_i;
  assign fire_req  = state_q == ST_SETUP && cnt_q == '0 && credit_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      data_q   <= '0;
      sym1_q   <= '0;
      sel_q    <= 1'b0;
      cnt_q    <= '0;
      offset_q <= '0;
      period_q <= '0;
      async_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          offset_q <= off_clamp;
          period_q <= period_i;
          async_q  <= offset_i == '0;
          if (take) begin
            data_q  <= word_i[SYM_W-1:0];
            sym1_q  <= word_i[HI_LSB +: SYM_W];
            sel_q   <= 1'b0;
            cnt_q   <= d0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (credit_open) begin
            state_q <= ST_ASSERT;
            cnt_q   <= d1;
          end
        end
        ST_ASSERT: begin
          if (async_q) begin
            if (ack_lvl) state_q <= ST_RELEASE;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            state_q <= ST_HOLD;
            cnt_q   <= d2;
          end
        end
        ST_HOLD: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        ST_RELEASE: ;
        default: state_q <= ST_IDLE;
      endcase

      if (sym_end) begin
        if (!sel_q) begin
          data_q  <= sym1_q;
          sel_q   <= 1'b1;
          cnt_q   <= d0;
          state_q <= ST_SETUP;
        end else if (word_valid_i) begin
          data_q  <= word_i[SYM_W-1:0];
          sym1_q  <= word_i[HI_LSB +: SYM_W];
          sel_q   <= 1'b0;
          cnt_q   <= d0;
          state_q <= ST_SETUP;
        end else begin
          state_q <= ST_IDLE;
        end
      end
    end
  end

  assign word_ready_o = need_word;
  assign req_o        = state_q == ST_ASSERT;
  assign data_o       = data_q;
  assign data_oe_o    = !idle;
  assign done_o       = idle && out_empty && !ack_lvl && !word_valid_i;

  AST_SYNC_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) && !async_q |-> out_cnt <= offset_q); // R5
  AST_ASYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) && async_q |-> out_cnt == CNT_W'(1)); // R7
  AST_DATA_UNDER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $stable(data_o)); // R2
  AST_REQ_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> !req_o); // R11
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o && !data_oe_o); // R9
endmodule

// File: tb/scsi_sync_tx_bench.sv
module scsi_sync_tx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [4:0]  offset_i = '0;
  logic [7:0]  period_i = '0;
  logic        ack_i = 1'b0;
  logic        req_o;
  logic [8:0]  data_o;
  logic        data_oe_o;
  logic        done_o;

  always #4 clk_i = ~clk_i;

  scsi_sync_tx u_scsi_sync_tx (
    .clk_i, .rst_ni, .word_i, .word_valid_i, .word_ready_o,
    .offset_i, .period_i, .ack_i, .req_o, .data_o, .data_oe_o, .done_o
  );

  // offset, period, words, ack gap
  localparam int NROW = 6;
  localparam int V_OFF [NROW] = '{4, 8, 15, 3, 2, 0};
  localparam int V_PER [NROW] = '{25, 50, 12, 100, 25, 25};
  localparam int V_NW  [NROW] = '{8, 6, 6, 4, 8, 5};
  localparam int V_GAP [NROW] = '{0, 0, 0, 0, 30, 0};

  int checks = 0, errors = 0;
  int cyc = 0, ncap = 0, tb_out = 0, max_out = 0;
  int last_rise = -1, min_int = 1000000, hi_bad = 0, exp_hi = 0;
  int ack_mode = 2, gap = 0, lowcnt = 0, hold = 0, lat = 0;
  logic req_prev = 1'b0;
  logic [8:0] cap [0:255];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dly0(input int per); return (per <= 25) ? 3 : 6; endfunction
  function automatic int dly1(input int per); return (per <= 25) ? 5 : 12; endfunction
  function automatic int dly2(input int per);
    int r;
    r = per * 4 / 8 - dly0(per) - dly1(per) - 3;
    if (r < 0) r = 0;
    if (r > 15) r = 15;
    return r;
  endfunction
  function automatic logic [8:0] sym(input int r, input int k);
    return 9'((r * 37 + k * 11 + 5) % 512);
  endfunction
  function automatic logic [31:0] mk_word(input int r, input int w);
    return {7'h55, sym(r, 2 * w + 1), 7'h2A, sym(r, 2 * w)};
  endfunction

  // bus monitor and ACK responder
  always @(negedge clk_i) begin
    cyc++;
    if (req_o && !req_prev) begin
      if (ncap < 256) cap[ncap] = data_o;
      ncap++;
      tb_out++;
      if (tb_out > max_out) max_out = tb_out;
      if (last_rise >= 0 && cyc - last_rise < min_int) min_int = cyc - last_rise;
      last_rise = cyc;
    end
    if (!req_o && req_prev && exp_hi > 0 && cyc - last_rise != exp_hi) hi_bad++;
    req_prev = req_o;
    case (ack_mode)
      0: begin
        if (ack_i) begin
          hold--;
          if (hold == 0) begin ack_i = 1'b0; lowcnt = 0; end
        end else begin
          lowcnt++;
          if (tb_out > 0 && lowcnt >= gap + 2) begin ack_i = 1'b1; hold = 2; tb_out--; end
        end
      end
      1: begin
        if (req_o) begin
          lat++;
          if (lat >= 3 && !ack_i) begin ack_i = 1'b1; tb_out--; end
        end else begin
          ack_i = 1'b0;
          lat = 0;
        end
      end
      default: ack_i = 1'b0;
    endcase
  end

  task automatic send_word(input logic [31:0] w);
    word_i = w;
    word_valid_i = 1'b1;
    @(negedge clk_i);
    while (!word_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    @(negedge clk_i);
    while (!done_o && t < 20000) begin @(negedge clk_i); t++; end
    check(done_o === 1'b1, req, done_o, 1);
  endtask

  task automatic clear_mon(input int mode, input int g, input int hi);
    ncap = 0; tb_out = 0; max_out = 0; last_rise = -1;
    min_int = 1000000; hi_bad = 0; exp_hi = hi; ack_mode = mode; gap = g;
    lowcnt = 0; hold = 0; lat = 0;
  endtask

  task automatic check_syms(input int r, input int nsym);
    int bad = 0;
    check(ncap == nsym, "R1", ncap, nsym);
    for (int k = 0; k < nsym && k < 256; k++) if (cap[k] !== sym(r, k)) bad++;
    check(bad == 0, "R1 R2 symbol mismatches", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state, R11 R9
    check(req_o == 1'b0, "R11 req after reset", req_o, 0);
    check(data_oe_o == 1'b0, "R11 oe after reset", data_oe_o, 0);
    check(done_o == 1'b1, "R9 done after reset", done_o, 1);

    // vector table
    for (int r = 0; r < NROW; r++) begin
      int off, per, hi, iv;
      off = V_OFF[r]; per = V_PER[r];
      hi = (off == 0) ? 0 : dly1(per) + 1;
      iv = dly0(per) + dly1(per) + dly2(per) + 3;
      offset_i = 5'(off); period_i = 8'(per);
      clear_mon((off == 0) ? 1 : 0, V_GAP[r], hi);
      repeat (3) @(posedge clk_i);
      #1;
      for (int w = 0; w < V_NW[r]; w++) send_word(mk_word(r, w));
      word_valid_i = 1'b0;
      wait_done("R9 R8 drain");
      check_syms(r, 2 * V_NW[r]);
      check(data_oe_o == 1'b0, "R11 oe after drain", data_oe_o, 0);
      if (off == 0) begin
        check(max_out == 1, "R7 R8 interlock", max_out, 1);
      end else begin
        check(hi_bad == 0, "R3 REQ width", hi_bad, 0);
        if (V_GAP[r] == 0) check(min_int == iv, "R3 R4 REQ spacing", min_int, iv);
        else check(max_out == off, "R5 window filled", max_out, off);
        check(max_out <= off, "R5 window bound", max_out, off);
      end
    end

    // done held back while ACKs are missing, R9 R11
    offset_i = 5'd4; period_i = 8'd25;
    clear_mon(2, 0, 6);
    repeat (3) @(posedge clk_i);
    #1;
    send_word(mk_word(7, 0));
    word_valid_i = 1'b0;
    repeat (200) @(negedge clk_i);
    check(ncap == 2, "R5 strobes sent without ACK", ncap, 2);
    check(done_o == 1'b0, "R9 done without ACK", done_o, 0);
    check(data_oe_o == 1'b0, "R11 oe idle with ACK pending", data_oe_o, 0);
    ack_mode = 0;
    wait_done("R9 done after late ACKs");
    check_syms(7, 2);

    // configuration ignored mid-transfer, R10
    offset_i = 5'd2; period_i = 8'd25;
    clear_mon(0, 40, 6);
    repeat (3) @(posedge clk_i);
    #1;
    send_word(mk_word(8, 0));
    offset_i = 5'd16; period_i = 8'd200;
    for (int w = 1; w < 6; w++) send_word(mk_word(8, w));
    word_valid_i = 1'b0;
    wait_done("R9");
    check(max_out == 2, "R10 offset kept", max_out, 2);
    check(hi_bad == 0, "R10 period kept", hi_bad, 0);
    check_syms(8, 12);

    // offset clamp, R6
    offset_i = 5'd31; period_i = 8'd25;
    clear_mon(0, 60, 6);
    repeat (3) @(posedge clk_i);
    #1;
    for (int w = 0; w < 20; w++) send_word(mk_word(9, w));
    word_valid_i = 1'b0;
    wait_done("R9");
    check(max_out == 16, "R6 clamped window", max_out, 16);
    check_syms(9, 40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule